// File: doc/BRIEF.md
# 1-Wire Bus Master Timing Engine

This block drives a single open-drain 1-Wire line. It never drives the line high. It pulls the line low by enabling a pad output driver whose data is tied to 0. To release the line it disables that driver, and the external pull-up raises it. All timing derives from a 6 us tick. The tick comes from a prescaler that divides the system clock by `CLK_MHZ * 6`.

A controller issues one command at a time through a start/busy/done handshake:

- **Bus reset.** A reset pulse followed by a presence window in which the line is sampled 32 times.
- **Write-0 slot.** One time slot that transmits a 0.
- **Write-1 slot.** One time slot that transmits a 1. It also serves as a read slot, because the engine samples the line inside it.
- **Byte transfer.** Eight slots back to back, least significant bit first.

Every slot yields one received bit. A write-0 slot yields a forced 0, so that the receive shift stays aligned with the slot count. Reading a byte means transferring 0xFF and taking the received byte.

Top module: `owm_engine`

## Requirements
- R1: One tick lasts `6*CLK_MHZ` clock cycles. The tick counter restarts on the edge that accepts a command, so tick boundary k of an operation falls exactly `k*6*CLK_MHZ` cycles after that edge.
- R2: After reset, `line_oe`, `busy`, `done`, `presence`, `rx_bit` and `rx_byte` are all 0. Whenever `busy` is 0, `line_oe` is 0.
- R3: `op` is sampled on the accepting edge with this encoding:
  - 2'b00: bus reset
  - 2'b01: write-0 slot
  - 2'b10: write-1 (read) slot
  - 2'b11: byte transfer of `tx_byte`
- R4: Bus reset timing:
  - The line stays released for ticks 0 to 9.
  - `line_oe` is high from tick boundary 10 until boundary 90.
  - `done` pulses at boundary 170.
- R5: During a bus reset, the line is sampled at tick boundaries 94, 96, … 156 (32 samples). `presence` is cleared on the accepting edge and set if any sample reads low. A low level that lies only between sample points does not set it.
- R6: Write-1 slot timing:
  - `line_oe` is high from boundary 3 to boundary 5.
  - The line is sampled at boundary 6, and `rx_bit` takes that level.
  - `done` pulses at boundary 15.
- R7: Write-0 slot timing:
  - `line_oe` is high from boundary 3 to boundary 15.
  - `done` pulses at boundary 15.
  - `rx_bit` is 0 whatever the line level.
- R8: A byte transfer runs eight slots with no gap. Slot i (i = 0..7) starts at boundary 15*i and sends `tx_byte[i]`, so the least significant bit goes first. `done` pulses once, at boundary 120.
- R9: Received bits fill `rx_byte` least significant bit first. Bit i is the level of slot i. `rx_byte` is valid from the cycle after the byte's `done` pulse. Transferring 0xFF returns the bits the bus presents.
- R10: `busy` rises on the edge that accepts `start`. While `busy` is high, `start` and `op` are ignored and the running operation keeps its timing.
- R11: `done` is a single-cycle pulse. It coincides with the first cycle in which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, accepted when not busy |
| op | input | 2 | Command code (R3) |
| tx_byte | input | 8 | Byte to send for a byte transfer |
| line_in | input | 1 | Sampled level of the 1-Wire line |
| line_oe | output | 1 | Enable of the low-driving pad driver |
| rx_bit | output | 1 | Bit received in the latest slot |
| rx_byte | output | 8 | Byte received by the latest byte transfer |
| presence | output | 1 | A device answered the latest bus reset |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at operation end |

## Verification
The bench builds the engine with `CLK_MHZ = 1`, which gives a six-cycle tick. At that size a full bus reset costs about a thousand cycles and a byte about seven hundred. This makes several sweeps affordable:

- Every one of the 32 presence sample points is hit, one at a time, with a one-cycle low pulse.
- The same pulse is also placed at every gap between sample points, and just outside both ends of the window.
- About thirty byte transfers run, each with a different pairing of transmit pattern and bus answer.

Because a tick is only a few cycles long, every edge of `line_oe` and every sample point can be checked to the exact clock cycle.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_W0    = 2'b01,
    OP_W1    = 2'b10,
    OP_BYTE  = 2'b11
  } owm_op_e;

  // Schedule positions, counted in 6 us ticks from the start of an operation
  localparam int TW          = 8;
  localparam int RST_LOW_BEG = 10;   // 60 us released
  localparam int RST_LOW_END = 90;   // 480 us low
  localparam int PRS_FIRST   = 94;   // 24 us after release
  localparam int PRS_LAST    = 156;  // 32 samples, 12 us apart
  localparam int RST_END     = 170;  // 480 us presence window
  localparam int SLOT_LOW    = 3;    // 18 us released
  localparam int SLOT_ONE_HI = 5;    // 12 us low for a 1
  localparam int SLOT_SMP    = 6;    // sample 6 us after release
  localparam int SLOT_END    = 15;   // 90 us per slot

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R1: ticks are isolated pulses when the divider exceeds one
      p_tick_isolated_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/owm_slot.sv
module owm_slot
  import owm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_rst,
  input  logic bit_in,
  input  logic chain,
  input  logic chain_bit,
  input  logic tick,
  input  logic line_in,
  output logic active,
  output logic oe,
  output logic done,
  output logic rbit,
  output logic presence
);
  logic [TW-1:0] t, nt, end_pt;
  logic          mode_rst, bit_q, drv, at_smp_rst, at_smp_bit;

  always_comb begin
    nt     = t + 1'b1;
    end_pt = mode_rst ? TW'(RST_END) : TW'(SLOT_END);
    if (mode_rst)
      drv = (nt >= TW'(RST_LOW_BEG)) && (nt < TW'(RST_LOW_END));
    else
      drv = (nt >= TW'(SLOT_LOW)) &&
            (nt < (bit_q ? TW'(SLOT_ONE_HI) : TW'(SLOT_END)));
    at_smp_rst = mode_rst && (nt >= TW'(PRS_FIRST)) &&
                 (nt <= TW'(PRS_LAST)) && !nt[0];
    at_smp_bit = !mode_rst && (nt == TW'(SLOT_SMP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      oe       <= 1'b0;
      done     <= 1'b0;
      rbit     <= 1'b0;
      presence <= 1'b0;
      t        <= '0;
      mode_rst <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        t        <= '0;
        mode_rst <= is_rst;
        bit_q    <= bit_in;
        oe       <= 1'b0;
        if (is_rst) presence <= 1'b0;
      end else if (active && tick) begin
        t  <= nt;
        oe <= drv;
        if (at_smp_rst && !line_in) presence <= 1'b1;
        if (at_smp_bit) rbit <= bit_q & line_in;
        if (nt == end_pt) begin
          done <= 1'b1;
          if (!mode_rst && chain) begin
            t     <= '0;
            bit_q <= chain_bit;
          end else begin
            active <= 1'b0;
          end
        end
      end
    end
  end

  // R2: released line whenever no operation runs
  p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
    !active |-> !oe);
  // R7: a zero slot never reports a one
  p_zero_forced_r7: assert property (@(posedge clk) disable iff (rst)
    active && tick && at_smp_bit && !bit_q |=> !rbit);
  // R5: presence starts cleared for each new reset
  p_presence_clr_r5: assert property (@(posedge clk) disable iff (rst)
    start && !active && is_rst |=> !presence);
  // R6: a slot pulls low only inside its low window
  p_slot_window_r6: assert property (@(posedge clk) disable iff (rst)
    active && !mode_rst && oe |-> (t >= TW'(SLOT_LOW)) && (t < TW'(SLOT_END)));
endmodule

// File: rtl/owm_shift.sv
module owm_shift #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NB-1:0] tx_byte,
  input  logic          slot_done,
  input  logic          rbit,
  output logic          byte_act,
  output logic          chain,
  output logic          chain_bit,
  output logic          byte_done,
  output logic [NB-1:0] rx_byte
);
  localparam int CNTW = $clog2(NB);
  localparam logic [CNTW-1:0] LAST = CNTW'(NB - 1);

  logic [CNTW-1:0] cnt;
  logic [NB-1:0]   tx_sr, rx_sr;

  assign chain     = byte_act && (cnt != LAST);
  assign chain_bit = tx_sr[1];
  assign byte_done = slot_done && byte_act && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_act <= 1'b0;
      cnt      <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_byte  <= '0;
    end else begin
      if (slot_done && byte_act) begin
        rx_sr <= {rbit, rx_sr[NB-1:1]};
        tx_sr <= tx_sr >> 1;
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          byte_act <= 1'b0;
          rx_byte  <= {rbit, rx_sr[NB-1:1]};
        end
      end
      if (load) begin
        byte_act <= 1'b1;
        cnt      <= '0;
        tx_sr    <= tx_byte;
      end
    end
  end

  // R8: slots between the first and the last keep chaining
  p_chain_busy_r8: assert property (@(posedge clk) disable iff (rst)
    slot_done && byte_act && (cnt != LAST) |=> byte_act);
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int NB      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [NB-1:0] tx_byte,
  input  logic          line_in,
  output logic          line_oe,
  output logic          rx_bit,
  output logic [NB-1:0] rx_byte,
  output logic          presence,
  output logic          busy,
  output logic          done
);
  localparam int DIV = CLK_MHZ * 6;

  logic go, tick, slot_done, byte_act, chain, chain_bit, byte_done;
  logic is_rst, first_bit;

  assign go        = start && !busy;
  assign is_rst    = (op == OP_RESET);
  assign first_bit = (op == OP_W1) || ((op == OP_BYTE) && tx_byte[0]);

  owm_tick #(.DIV(DIV)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (go),
    .tick (tick)
  );

  owm_slot i_slot (
    .clk       (clk),
    .rst       (rst),
    .start     (go),
    .is_rst    (is_rst),
    .bit_in    (first_bit),
    .chain     (chain),
    .chain_bit (chain_bit),
    .tick      (tick),
    .line_in   (line_in),
    .active    (busy),
    .oe        (line_oe),
    .done      (slot_done),
    .rbit      (rx_bit),
    .presence  (presence)
  );

  owm_shift #(.NB(NB)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (go && (op == OP_BYTE)),
    .tx_byte   (tx_byte),
    .slot_done (slot_done),
    .rbit      (rx_bit),
    .byte_act  (byte_act),
    .chain     (chain),
    .chain_bit (chain_bit),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  assign done = byte_done || (slot_done && !byte_act);

  // R10: a request during an operation does not end it early
  p_busy_holds_r10: assert property (@(posedge clk) disable iff (rst)
    busy && start && !slot_done |=> busy || done);
  // R11: completion is a single pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11: completion coincides with the engine being idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/test_owm_engine.sv
module test_owm_engine;
  localparam int CLK_MHZ = 1;
  localparam int D  = 6 * CLK_MHZ;
  localparam int SL = 15 * D;

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0, dev_low = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] tx_byte = 8'h00, rx_byte;
  logic       line_in, line_oe, rx_bit, presence, busy, done;

  assign line_in = !(line_oe || dev_low);

  owm_engine #(.CLK_MHZ(CLK_MHZ)) i_owm_engine (
    .clk(clk), .rst(rst), .start(start), .op(op), .tx_byte(tx_byte),
    .line_in(line_in), .line_oe(line_oe), .rx_bit(rx_bit),
    .rx_byte(rx_byte), .presence(presence), .busy(busy), .done(done)
  );

  always #2 clk = !clk;

  int tests = 0, fails = 0, cyc = 0;
  int win_lo = -1, win_hi = -1;
  bit pat_en = 0;
  logic [7:0] pat = 8'hFF;
  int rise [8];
  int fall [8];
  int nr, nf, done_e, busy0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic dl(input int k);
    logic r;
    r = (k >= win_lo) && (k < win_hi);
    if (pat_en && (k % SL) == 6 * D && (k / SL) < 8 && !pat[3'(k / SL)]) r = 1'b1;
    return r;
  endfunction

  task automatic run(input logic [1:0] o, input logic [7:0] tb, input bit hold);
    int rel;
    int e;
    logic prev;
    @(negedge clk);
    start = 1'b1; op = o; tx_byte = tb; dev_low = 1'b0;
    @(posedge clk);
    rel = 0; prev = 1'b0; nr = 0; nf = 0; done_e = -1; busy0 = 0;
    while (done_e < 0 && rel < 3000) begin
      @(negedge clk);
      rel++;
      e = rel - 1;
      if (hold && e < 20) begin start = 1'b1; op = 2'b00; tx_byte = 8'h00; end
      else start = 1'b0;
      dev_low = dl(rel);
      if (e == 0) busy0 = busy;
      if (line_oe && !prev) begin if (nr < 8) rise[nr] = e; nr++; end
      if (!line_oe && prev) begin if (nf < 8) fall[nf] = e; nf++; end
      prev = line_oe;
      if (done) done_e = e;
    end
    @(negedge clk);
    dev_low = 1'b0;
    start = 1'b0;
    chk(!done && !busy, "R11 done single pulse", int'(done), 0);
  endtask

  initial begin : watchdog
    while (cyc < 190000) @(posedge clk) cyc++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] tv, pv, got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk(!line_oe && !busy && !done && !presence, "R2 idle outputs", int'(line_oe | busy | presence), 0);
    chk(rx_byte == 8'h00 && !rx_bit, "R2 rx cleared", int'(rx_byte), 0);

    // R4 R1 R3 reset timing, no device
    win_lo = -1; win_hi = -1; pat_en = 0;
    run(2'b00, 8'h00, 0);
    chk(busy0 == 1, "R10 busy after accept", busy0, 1);
    chk(nr == 1 && rise[0] == 10 * D, "R4 low start", rise[0], 10 * D);
    chk(nf == 1 && fall[0] == 90 * D, "R4 low end", fall[0], 90 * D);
    chk(done_e == 170 * D, "R4 done time", done_e, 170 * D);
    chk(!presence, "R5 no device", int'(presence), 0);

    // R5 presence sweep over sample points and gaps
    for (int j = 0; j < 32; j++) begin
      win_lo = (94 + 2 * j) * D; win_hi = win_lo + 1;
      run(2'b00, 8'h00, 0);
      chk(presence, "R5 sample hit", int'(presence), 1);
      win_lo = (95 + 2 * j) * D; win_hi = win_lo + 1;
      run(2'b00, 8'h00, 0);
      chk(!presence, "R5 gap ignored", int'(presence), 0);
    end
    win_lo = 92 * D; win_hi = win_lo + 1;
    run(2'b00, 8'h00, 0);
    chk(!presence, "R5 before window", int'(presence), 0);
    win_lo = 158 * D; win_hi = win_lo + 1;
    run(2'b00, 8'h00, 0);
    chk(!presence, "R5 after window", int'(presence), 0);

    // R6 write-1 / read slot
    for (int s = 0; s < 4; s++) begin
      win_lo = (s == 0) ? -1 : (4 + s) * D;
      win_hi = (s == 0) ? -1 : win_lo + 1;
      run(2'b10, 8'h00, 0);
      chk(nr == 1 && rise[0] == 3 * D, "R6 low start", rise[0], 3 * D);
      chk(nf == 1 && fall[0] == 5 * D, "R6 low end", fall[0], 5 * D);
      chk(done_e == 15 * D, "R6 done time", done_e, 15 * D);
      chk(rx_bit == (s != 2), "R6 sampled bit", int'(rx_bit), int'(s != 2));
    end

    // R7 write-0 slot, line high at the sample point
    win_lo = -1; win_hi = -1;
    run(2'b01, 8'h00, 0);
    chk(nr == 1 && rise[0] == 3 * D, "R7 low start", rise[0], 3 * D);
    chk(nf == 1 && fall[0] == 15 * D, "R7 low end", fall[0], 15 * D);
    chk(done_e == 15 * D, "R7 done time", done_e, 15 * D);
    chk(!rx_bit, "R7 forced zero", int'(rx_bit), 0);

    // R8 R9 byte sweep
    pat_en = 1;
    for (int v = 0; v < 32; v++) begin
      tv = 8'((v * 37 + 5) & 255);
      pv = 8'((v * 73 + 11) & 255);
      if (v == 31) tv = 8'hFF;
      pat = pv;
      run(2'b11, tv, 0);
      got = 8'h00;
      for (int i = 0; i < 8; i++) begin
        chk(rise[i] == SL * i + 3 * D, "R8 slot start", rise[i], SL * i + 3 * D);
        got[i] = ((fall[i] - rise[i]) == 2 * D);
      end
      chk(nr == 8 && nf == 8, "R8 slot count", nr, 8);
      chk(got == tv, "R8 bits LSB first", int'(got), int'(tv));
      chk(done_e == 120 * D, "R8 done time", done_e, 120 * D);
      chk(rx_byte == (tv & pv), "R9 received byte", int'(rx_byte), int'(tv & pv));
    end

    // R10 start held and op changed during a byte
    pat = 8'h3C;
    run(2'b11, 8'hFF, 1);
    chk(nr == 8 && done_e == 120 * D, "R10 request ignored", done_e, 120 * D);
    chk(rx_byte == 8'h3C, "R10 byte intact", int'(rx_byte), 8'h3C);
    repeat (30) @(negedge clk);
    chk(!busy && !line_oe, "R10 no queued command", int'(busy), 0);
    pat_en = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule